// File: doc/BRIEF.md
# Deflection Routing Node

This block is one routing node of a slotted, self-routing packet fabric built from concentric rings of nodes. Each time slot the node accepts at most one packet. The packet comes either from the previous node on its own ring (the same-ring input) or from a node on the next ring outward (the outer input). The node holds the packet for one slot. It then sends the packet either onward along its own ring (forward) or down to the next ring inward (down). The move down keeps the height index unchanged.

Each ring level resolves exactly one destination address bit. A packet moves down only when that bit equals the same bit of the node's own height index, and only if the inner ring has not reserved the landing spot. In every other case the packet is deflected forward. Reservations travel as a single blocking wire. The inner neighbour raises `blk_in` in the slot in which its own packet will take the spot this node would drop into. This node raises `blk_out` toward its outer competitor whenever its arriving packet is going forward. Because of this lookahead the node never has to choose between two packets. The payload is carried untouched.

Top module: `dvx_route_node`

## Requirements
- R1: After reset has been applied and released, `fwd_vld` and `down_vld` are 0 and all output address and data fields are 0 until the first packet has been captured.
- R2: A packet presented on an input leaves on exactly one output. It carries its address and payload unchanged, so no packet is dropped or duplicated, and `fwd_vld` and `down_vld` are never both 1.
- R3: A captured packet leaves on the down output when its address bit at index LEVEL equals `my_height[LEVEL]` and `blk_in` was 0 in the arrival slot. Every packet on the down output has that address bit equal to the node's height bit.
- R4: A packet whose address bit at index LEVEL differs from `my_height[LEVEL]` leaves on the forward output.
- R5: A packet that arrives while `blk_in` is 1 leaves on the forward output even when its address bit matches.
- R6: `blk_out` is 1 in exactly those slots whose arriving packet will leave forward in the next slot. It is combinational from the current inputs, so the outer competitor sees it one slot before the protected packet lands downstream.
- R7: The same-ring input has priority over the outer input, and a packet from the outer input is steered by the same rule as one from the same-ring input. At most one of `same_vld` and `outer_vld` may be 1 in a slot.
- R8: An empty slot (both valid bits 0) never raises `blk_out`, whatever `blk_in` is. It propagates as an empty slot: both output valids 0 and all output fields 0, whatever values sit on the input address and data lines.
- R9: A packet captured at a clock edge is present on its output for exactly the one slot that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| my_height | input | ADDR_W | Height index of this node |
| same_vld | input | 1 | Framing bit of the same-ring input |
| same_addr | input | ADDR_W | Destination address of the same-ring input |
| same_data | input | DATA_W | Payload of the same-ring input |
| outer_vld | input | 1 | Framing bit of the outer input |
| outer_addr | input | ADDR_W | Destination address of the outer input |
| outer_data | input | DATA_W | Payload of the outer input |
| blk_in | input | 1 | Reservation from the inner neighbour; forbids moving down |
| blk_out | output | 1 | Reservation to the outer competitor |
| fwd_vld | output | 1 | Framing bit on the forward (same-ring) output |
| fwd_addr | output | ADDR_W | Address on the forward output |
| fwd_data | output | DATA_W | Payload on the forward output |
| down_vld | output | 1 | Framing bit on the down (inner-ring) output |
| down_addr | output | ADDR_W | Address on the down output |
| down_data | output | DATA_W | Payload on the down output |

## Verification
`blk_out` is due in the same slot as the arrival that causes it. The bench therefore samples it one nanosecond after driving the inputs, before any clock edge. The steered packet is due one edge later. The bench drives on a falling edge and compares every output on the next falling edge, so exactly one rising edge has occurred in between. The reference model keeps only the expected route and fields of the previous slot. A packet held over two slots, or one released too early, therefore shows up as a mismatch in the following comparison.

// File: rtl/dvx_route_pkg.sv
package dvx_route_pkg;

  // Route given to the packet held in the slot register.
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_FWD  = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

endpackage

// File: rtl/dvx_rst_sync.sv
module dvx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dvx_arrival_sel.sv
module dvx_arrival_sel #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              same_vld,
  input  logic [ADDR_W-1:0] same_addr,
  input  logic [DATA_W-1:0] same_data,
  input  logic              outer_vld,
  input  logic [ADDR_W-1:0] outer_addr,
  input  logic [DATA_W-1:0] outer_data,
  output logic              arr_vld,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);

  // Same-ring traffic wins; the reservation scheme keeps both from
  // arriving together, so this order only matters for illegal input.
  always_comb begin
    arr_vld  = 1'b0;
    arr_addr = '0;
    arr_data = '0;
    if (same_vld) begin
      arr_vld  = 1'b1;
      arr_addr = same_addr;
      arr_data = same_data;
    end else if (outer_vld) begin
      arr_vld  = 1'b1;
      arr_addr = outer_addr;
      arr_data = outer_data;
    end
  end

endmodule

// File: rtl/dvx_route_dec.sv
module dvx_route_dec
  import dvx_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LEVEL  = 2
) (
  input  logic              arr_vld,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [ADDR_W-1:0] my_height,
  input  logic              blk_in,
  output dir_e              dir_o,
  output logic              blk_out
);

  logic bit_hit;

  always_comb begin
    bit_hit = (arr_addr[LEVEL] == my_height[LEVEL]);
    if (!arr_vld) begin
      dir_o = DIR_NONE;
    end else if (bit_hit && !blk_in) begin
      dir_o = DIR_DOWN;
    end else begin
      dir_o = DIR_FWD;
    end
  end

  // A packet staying on this ring reserves the downstream node against
  // the outer competitor for the same landing slot.
  assign blk_out = (dir_o == DIR_FWD);

endmodule

// File: rtl/dvx_slot_reg.sv
module dvx_slot_reg
  import dvx_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  dir_e              dir_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] data_d,
  output logic              fwd_vld,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              down_vld,
  output logic [ADDR_W-1:0] down_addr,
  output logic [DATA_W-1:0] down_data
);

  dir_e              dir_q,  dir_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;

  // Next state: an empty slot carries cleared fields.
  always_comb begin
    dir_n  = dir_d;
    addr_n = (dir_d == DIR_NONE) ? '0 : addr_d;
    data_n = (dir_d == DIR_NONE) ? '0 : data_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dir_q  <= DIR_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      dir_q  <= dir_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  always_comb begin
    fwd_vld   = (dir_q == DIR_FWD);
    down_vld  = (dir_q == DIR_DOWN);
    fwd_addr  = fwd_vld  ? addr_q : '0;
    fwd_data  = fwd_vld  ? data_q : '0;
    down_addr = down_vld ? addr_q : '0;
    down_data = down_vld ? data_q : '0;
  end

  // R2: a held packet leaves by one exit only.
  p_single_exit_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !(fwd_vld && down_vld));

  // R9: a slot register that received nothing shows nothing next slot.
  p_hold_one_slot_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (dir_d == DIR_NONE) |=> (!fwd_vld && !down_vld));

endmodule

// File: rtl/dvx_route_node.sv
module dvx_route_node
  import dvx_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int LEVEL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_height,
  input  logic              same_vld,
  input  logic [ADDR_W-1:0] same_addr,
  input  logic [DATA_W-1:0] same_data,
  input  logic              outer_vld,
  input  logic [ADDR_W-1:0] outer_addr,
  input  logic [DATA_W-1:0] outer_data,
  input  logic              blk_in,
  output logic              blk_out,
  output logic              fwd_vld,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              down_vld,
  output logic [ADDR_W-1:0] down_addr,
  output logic [DATA_W-1:0] down_data
);

  logic              srst_n;
  logic              arr_vld;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;
  dir_e              route;

  dvx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dvx_arrival_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arrival_sel (
    .same_vld   (same_vld),
    .same_addr  (same_addr),
    .same_data  (same_data),
    .outer_vld  (outer_vld),
    .outer_addr (outer_addr),
    .outer_data (outer_data),
    .arr_vld    (arr_vld),
    .arr_addr   (arr_addr),
    .arr_data   (arr_data)
  );

  dvx_route_dec #(.ADDR_W(ADDR_W), .LEVEL(LEVEL)) u_route_dec (
    .arr_vld   (arr_vld),
    .arr_addr  (arr_addr),
    .my_height (my_height),
    .blk_in    (blk_in),
    .dir_o     (route),
    .blk_out   (blk_out)
  );

  dvx_slot_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot_reg (
    .clk       (clk),
    .srst_n    (srst_n),
    .dir_d     (route),
    .addr_d    (arr_addr),
    .data_d    (arr_data),
    .fwd_vld   (fwd_vld),
    .fwd_addr  (fwd_addr),
    .fwd_data  (fwd_data),
    .down_vld  (down_vld),
    .down_addr (down_addr),
    .down_data (down_data)
  );

  p_down_on_match_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (arr_vld && !blk_in && (arr_addr[LEVEL] == my_height[LEVEL]))
      |=> (down_vld && (down_data == $past(arr_data))));

  p_down_bit_agrees_r3: assert property (@(posedge clk) disable iff (!srst_n)
    down_vld |-> (down_addr[LEVEL] == $past(my_height[LEVEL])));

  p_fwd_on_mismatch_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (arr_vld && (arr_addr[LEVEL] != my_height[LEVEL]))
      |=> (fwd_vld && (fwd_addr == $past(arr_addr))));

  p_fwd_when_blocked_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (arr_vld && blk_in) |=> fwd_vld);

  p_reserve_means_fwd_r6: assert property (@(posedge clk) disable iff (!srst_n)
    blk_out |=> fwd_vld);

  p_legal_arrival_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !(same_vld && outer_vld));

  p_empty_stays_empty_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!same_vld && !outer_vld)
      |-> (!blk_out ##1 (!fwd_vld && !down_vld && fwd_data == '0 && down_data == '0)));

endmodule

// File: tb/dvx_route_node_bench.sv
`timescale 1ns/1ps
module dvx_route_node_bench;

  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int LVL = 2;
  localparam logic [AW-1:0] HEIGHT = 4'b0110;  // bit LVL is 1

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] my_height;
  logic          same_vld, outer_vld, blk_in;
  logic [AW-1:0] same_addr, outer_addr;
  logic [DW-1:0] same_data, outer_data;
  logic          blk_out, fwd_vld, down_vld;
  logic [AW-1:0] fwd_addr, down_addr;
  logic [DW-1:0] fwd_data, down_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected outputs for the slot after the one just driven
  int exp_dir = 0;  // 0 empty, 1 forward, 2 down
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  dvx_route_node #(.ADDR_W(AW), .DATA_W(DW), .LEVEL(LVL)) u_dvx_route_node (
    .clk(clk), .rst_n(rst_n), .my_height(my_height),
    .same_vld(same_vld), .same_addr(same_addr), .same_data(same_data),
    .outer_vld(outer_vld), .outer_addr(outer_addr), .outer_data(outer_data),
    .blk_in(blk_in), .blk_out(blk_out),
    .fwd_vld(fwd_vld), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
    .down_vld(down_vld), .down_addr(down_addr), .down_data(down_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare all outputs with the expectation from the previous slot.
  task automatic check_outputs(input string req);
    chk(req, "fwd_vld",  fwd_vld,  exp_dir == 1);
    chk(req, "down_vld", down_vld, exp_dir == 2);
    chk("R2", "fwd_addr",  fwd_addr,  (exp_dir == 1) ? exp_addr : '0);
    chk("R2", "fwd_data",  fwd_data,  (exp_dir == 1) ? exp_data : '0);
    chk("R2", "down_addr", down_addr, (exp_dir == 2) ? exp_addr : '0);
    chk("R2", "down_data", down_data, (exp_dir == 2) ? exp_data : '0);
  endtask

  // One slot: drive at a falling edge, check blk_out at once, check the
  // steered packet at the next falling edge (one rising edge later, R9).
  task automatic slot(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic ov, input logic [AW-1:0] oa, input logic [DW-1:0] od,
                      input logic blk, input string req);
    logic          pv;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;
    same_vld = sv;  same_addr = sa;  same_data = sd;
    outer_vld = ov; outer_addr = oa; outer_data = od;
    blk_in = blk;
    pv = sv | ov;
    pa = sv ? sa : oa;
    pd = sv ? sd : od;
    if (!pv) exp_dir = 0;
    else if ((((pa >> LVL) & 1) == ((my_height >> LVL) & 1)) && !blk) exp_dir = 2;
    else exp_dir = 1;
    exp_addr = pa;
    exp_data = pd;
    #1;
    chk(pv ? "R6" : "R8", "blk_out", blk_out, exp_dir == 1);
    @(negedge clk);
    check_outputs(req);
  endtask

  initial begin
    rst_n = 1'b0;
    my_height = HEIGHT;
    same_vld = 0; outer_vld = 0; blk_in = 0;
    same_addr = '0; outer_addr = '0; same_data = '0; outer_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check_outputs("R1");
    end

    // R3: matching bit, no reservation -> down
    slot(1, 4'b0100, 16'hA001, 0, '0, '0, 0, "R3");
    // R4: mismatching bit -> forward
    slot(1, 4'b0011, 16'hA002, 0, '0, '0, 0, "R4");
    // R5: matching but reserved below -> forward
    slot(1, 4'b1101, 16'hA003, 0, '0, '0, 1, "R5");
    // R7: outer input, same rule
    slot(0, '0, '0, 1, 4'b0111, 16'hB001, 0, "R7");
    slot(0, '0, '0, 1, 4'b1000, 16'hB002, 0, "R7");
    slot(0, '0, '0, 1, 4'b1111, 16'hB003, 1, "R7");
    // R8: empty slot with garbage lines and blk_in high
    slot(0, 4'b0100, 16'hDEAD, 0, 4'b0100, 16'hBEEF, 1, "R8");
    slot(0, 4'b1111, 16'hFFFF, 0, 4'b0000, 16'h1234, 0, "R8");
    // R9: back-to-back, alternating exits, then empty
    slot(1, 4'b0100, 16'hC001, 0, '0, '0, 0, "R9");
    slot(0, '0, '0, 1, 4'b0000, 16'hC002, 0, "R9");
    slot(1, 4'b1110, 16'hC003, 0, '0, '0, 0, "R9");
    slot(0, '0, '0, 0, '0, '0, 0, "R9");

    // R2: random legal traffic, every packet tracked to its exit
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = $urandom_range(0, 2);
      slot(kind == 1, AW'($urandom), DW'($urandom),
           kind == 2, AW'($urandom), DW'($urandom),
           1'($urandom), "R2");
    end

    slot(0, '0, '0, 0, '0, '0, 0, "R8");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule